// File: doc/BRIEF.md
# Row-by-Row DRAM Refresh Controller

This block keeps one DRAM bank's contents alive by rewriting each row before its charge can leak away. A row pointer steps through the bank. Each row is refreshed by an explicit activate command, followed after the row-active time by a precharge command. A cycle timer derived from the clock rate, the retention window and the row count paces the requests, so every row is visited once per window.

Two pacing modes are available:

- **Distributed:** one row is refreshed every `window / rows` time. This gives many short pauses.
- **Burst:** the remaining rows are refreshed back to back once per window. This gives one long pause.

While a refresh is in progress, `ref_busy` is high, and the request scheduler must keep its own traffic off the bank. The block starts a refresh only when the scheduler reports that no normal command is in flight. If the scheduler reports an open row, the block closes it before the first activate. The mode and the open-row flag are sampled once, when a refresh is accepted.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: In distributed mode each accepted request refreshes exactly one row. With no interference, consecutive refreshes begin exactly `INTERVAL = CLK_KHZ*WINDOW_MS/ROWS` cycles apart.
- R2: Every activate is followed by a precharge exactly `T_RAS` cycles later. `cmd_kind` encodes 1 = activate and 2 = precharge; 0 is never issued.
- R3: If `row_open` is high when a refresh is accepted, the first command is a precharge, and the activate follows exactly `T_RP` cycles later.
- R4: In burst mode the rows from the current pointer up to `ROWS-1` are refreshed in ascending order, each activate `T_RP` cycles after the previous precharge. Full sweeps recur every `ROWS*INTERVAL` cycles.
- R5: Rows are refreshed in increasing order and the pointer wraps to 0 after `ROWS-1`. `sweep_done` pulses for one cycle when the refresh of row `ROWS-1` finishes, in the same cycle in which `ref_busy` falls.
- R6: `ref_busy` rises in the same cycle as the first command of a refresh and stays high until the wait after the final precharge ends. No command is issued while it is low.
- R7: No refresh is accepted while `sched_busy` is high. A request that falls due then is held and serviced once `sched_busy` drops, and requests raised during such a hold merge into one.
- R8: While `rst` is high, and just after it, all outputs are 0. The row pointer restarts at 0, even when reset lands in the middle of a burst.
- R9: `mode_burst` and `row_open` are sampled only at acceptance. Changing them during a refresh does not alter the command sequence of that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_burst | input | 1 | 1 = burst pacing, 0 = distributed pacing |
| row_open | input | 1 | Scheduler reports a row currently open in the bank |
| sched_busy | input | 1 | A normal command is still in progress |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 2 | 1 = activate, 2 = precharge |
| cmd_row | output | clog2(ROWS) | Row addressed by the activate |
| ref_busy | output | 1 | Bank is reserved for refresh |
| sweep_done | output | 1 | One-cycle pulse when the last row has been refreshed |

## Verification
The main function is tried with a table of episodes. Each episode combines a pacing mode, a closed or open row, and the scheduler either free or holding the bank. The patterns tell apart three things: whether a precharge correctly comes first, whether one row or the rest of the bank is swept, and whether a held request is deferred rather than lost or repeated. Several episodes flip the mode and open-row inputs in the middle of a refresh, which separates sampling at acceptance from continuous sampling. Directed runs measure the start-to-start spacing in both modes and restart the row order by resetting in the middle of a burst.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_PRE = 2'd2
  } dram_cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE       = 2'd0,
    SQ_CLOSE_WAIT = 2'd1,
    SQ_ACT_WAIT   = 2'd2,
    SQ_PRE_WAIT   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
// Paces refresh: a row tick every INTERVAL cycles, a window tick every ROWS row ticks.
module rfsh_interval_timer #(
  parameter int INTERVAL = 488,
  parameter int ROWS     = 16384
) (
  input  logic clk,
  input  logic rst,
  output logic row_tick,
  output logic window_tick
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam int IDX_W = $clog2(ROWS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ROWS - 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      idx         <= '0;
      row_tick    <= 1'b0;
      window_tick <= 1'b0;
    end else begin
      row_tick    <= 1'b0;
      window_tick <= 1'b0;
      if (cnt == CNT_LAST) begin
        cnt      <= '0;
        row_tick <= 1'b1;
        if (idx == IDX_LAST) begin
          idx         <= '0;
          window_tick <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfsh_request_latch.sv
// Holds one outstanding refresh request; requests arriving while one is held merge.
module rfsh_request_latch (
  input  logic clk,
  input  logic rst,
  input  logic mode_burst,
  input  logic row_tick,
  input  logic window_tick,
  input  logic take,
  output logic pending
);
  logic req;
  assign req = mode_burst ? window_tick : row_tick;

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= req | (pending & ~take);
  end
endmodule

// File: rtl/rfsh_row_counter.sv
// Row pointer with wrap after the last row.
module rfsh_row_counter #(
  parameter int ROWS  = 16384,
  parameter int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] row_q,
  output logic [ROW_W-1:0] row_nxt,
  output logic             at_last
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  assign at_last = (row_q == ROW_LAST);
  assign row_nxt = at_last ? '0 : row_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       row_q <= '0;
    else if (step) row_q <= row_nxt;
  end
endmodule

// File: rtl/rfsh_sequencer.sv
// Command sequencer: optional close, then activate / precharge per row with timing waits.
module rfsh_sequencer
  import refresh_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int T_RAS = 4,
  parameter int T_RP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             sched_busy,
  input  logic             mode_burst,
  input  logic             row_open,
  input  logic [ROW_W-1:0] row_q,
  input  logic [ROW_W-1:0] row_nxt,
  input  logic             at_last,
  output logic             take,
  output logic             step,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic             ref_busy,
  output logic             sweep_done
);
  localparam int T_MAX  = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int WAIT_W = $clog2(T_MAX + 1);
  localparam logic [WAIT_W-1:0] RAS_LOAD = WAIT_W'(T_RAS - 1);
  localparam logic [WAIT_W-1:0] RP_LOAD  = WAIT_W'(T_RP - 1);

  seq_state_e        st;
  logic [WAIT_W-1:0] wait_cnt;
  logic              wait_z;
  logic              burst_q;

  assign wait_z = (wait_cnt == '0);
  assign take   = (st == SQ_IDLE) && pending && !sched_busy;
  assign step   = (st == SQ_PRE_WAIT) && wait_z;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      wait_cnt   <= '0;
      burst_q    <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_kind   <= CMD_NOP;
      cmd_row    <= '0;
      ref_busy   <= 1'b0;
      sweep_done <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      sweep_done <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (take) begin
            ref_busy  <= 1'b1;
            burst_q   <= mode_burst;
            cmd_valid <= 1'b1;
            if (row_open) begin
              cmd_kind <= CMD_PRE;
              wait_cnt <= RP_LOAD;
              st       <= SQ_CLOSE_WAIT;
            end else begin
              cmd_kind <= CMD_ACT;
              cmd_row  <= row_q;
              wait_cnt <= RAS_LOAD;
              st       <= SQ_ACT_WAIT;
            end
          end
        end
        SQ_CLOSE_WAIT: begin
          if (wait_z) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CMD_ACT;
            cmd_row   <= row_q;
            wait_cnt  <= RAS_LOAD;
            st        <= SQ_ACT_WAIT;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        SQ_ACT_WAIT: begin
          if (wait_z) begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CMD_PRE;
            wait_cnt  <= RP_LOAD;
            st        <= SQ_PRE_WAIT;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        SQ_PRE_WAIT: begin
          if (wait_z) begin
            sweep_done <= at_last;
            if (burst_q && !at_last) begin
              cmd_valid <= 1'b1;
              cmd_kind  <= CMD_ACT;
              cmd_row   <= row_nxt;
              wait_cnt  <= RAS_LOAD;
              st        <= SQ_ACT_WAIT;
            end else begin
              ref_busy <= 1'b0;
              st       <= SQ_IDLE;
            end
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROWS      = 16384,
  parameter int CLK_KHZ   = 125000,
  parameter int WINDOW_MS = 64,
  parameter int T_RAS     = 4,
  parameter int T_RP      = 2,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int INTERVAL = (CLK_KHZ * WINDOW_MS) / ROWS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_burst,
  input  logic             row_open,
  input  logic             sched_busy,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [ROW_W-1:0] cmd_row,
  output logic             ref_busy,
  output logic             sweep_done
);
  logic             row_tick, window_tick, pending, take, step, at_last;
  logic [ROW_W-1:0] row_q, row_nxt;

  rfsh_interval_timer #(.INTERVAL(INTERVAL), .ROWS(ROWS)) u_timer (
    .clk(clk), .rst(rst), .row_tick(row_tick), .window_tick(window_tick)
  );

  rfsh_request_latch u_req (
    .clk(clk), .rst(rst), .mode_burst(mode_burst), .row_tick(row_tick),
    .window_tick(window_tick), .take(take), .pending(pending)
  );

  rfsh_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst(rst), .step(step), .row_q(row_q), .row_nxt(row_nxt),
    .at_last(at_last)
  );

  rfsh_sequencer #(.ROW_W(ROW_W), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst(rst), .pending(pending), .sched_busy(sched_busy),
    .mode_burst(mode_burst), .row_open(row_open), .row_q(row_q),
    .row_nxt(row_nxt), .at_last(at_last), .take(take), .step(step),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_row(cmd_row),
    .ref_busy(ref_busy), .sweep_done(sweep_done)
  );
endmodule

// File: rtl/rfsh_checker.sv
module rfsh_checker
  import refresh_pkg::*;
#(
  parameter int ROWS  = 16384,
  parameter int T_RAS = 4,
  parameter int T_RP  = 2,
  localparam int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst,
  input logic             sched_busy,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic [ROW_W-1:0] cmd_row,
  input logic             ref_busy,
  input logic             sweep_done
);
  logic [15:0]      gap;
  logic [1:0]       last_kind;
  logic [ROW_W-1:0] last_act_row;
  logic             act_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0; last_kind <= CMD_NOP; last_act_row <= '0; act_seen <= 1'b0;
    end else begin
      if (cmd_valid) gap <= 16'd1;
      else if (gap != 16'hFFFF) gap <= gap + 16'd1;
      if (!ref_busy) begin
        last_kind <= CMD_NOP;
        act_seen  <= 1'b0;
      end else if (cmd_valid) begin
        last_kind <= cmd_kind;
        if (cmd_kind == CMD_ACT) begin
          last_act_row <= cmd_row;
          act_seen     <= 1'b1;
        end
      end
    end
  end

  AST_CMD_CODE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_kind == CMD_ACT || cmd_kind == CMD_PRE)); // R2
  AST_RAS_GAP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == CMD_PRE && last_kind == CMD_ACT) |-> gap == 16'(T_RAS)); // R2
  AST_RP_GAP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == CMD_ACT && last_kind == CMD_PRE) |-> gap == 16'(T_RP)); // R3
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == CMD_ACT && act_seen) |-> cmd_row == ROW_W'(last_act_row + 1'b1)); // R4
  AST_SWEEP_PULSE: assert property (@(posedge clk) disable iff (rst)
    sweep_done |=> !sweep_done); // R5
  AST_SWEEP_AT_END: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> $fell(ref_busy)); // R5
  AST_CMD_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ref_busy); // R6
  AST_FIRST_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_busy) |-> cmd_valid); // R6
  AST_START_FREE: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_busy) |-> !$past(sched_busy)); // R7
endmodule

bind dram_refresh_ctrl rfsh_checker #(.ROWS(ROWS), .T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst(rst), .sched_busy(sched_busy), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .cmd_row(cmd_row), .ref_busy(ref_busy),
  .sweep_done(sweep_done)
);

// File: tb/test_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module test_dram_refresh_ctrl;
  localparam int ROWS = 8, CLK_KHZ = 5, WINDOW_MS = 64, T_RAS = 4, T_RP = 2;
  localparam int INTERVAL = CLK_KHZ * WINDOW_MS / ROWS;  // 40
  localparam int ROW_W = $clog2(ROWS);
  localparam int HOLD = 50;
  localparam logic [1:0] K_ACT = 2'd1, K_PRE = 2'd2;
  // {burst, open, hold, expected first command kind}
  localparam logic [4:0] SCEN [8] = '{
    {3'b000, K_ACT}, {3'b010, K_PRE}, {3'b001, K_ACT}, {3'b100, K_ACT},
    {3'b110, K_PRE}, {3'b101, K_ACT}, {3'b011, K_PRE}, {3'b000, K_ACT}};

  logic clk = 0, rst = 1, mode_burst = 0, row_open = 0, sched_busy = 0;
  logic cmd_valid, ref_busy, sweep_done;
  logic [1:0] cmd_kind;
  logic [ROW_W-1:0] cmd_row;

  int total = 0, bad = 0, cyc = 0, log_n = 0, model_row = 0, last_start = 0;
  int log_cyc [64];
  logic [1:0] log_kind [64];
  int log_row [64];
  bit done = 0;

  always #4 clk = ~clk;

  dram_refresh_ctrl #(.ROWS(ROWS), .CLK_KHZ(CLK_KHZ), .WINDOW_MS(WINDOW_MS),
    .T_RAS(T_RAS), .T_RP(T_RP)) i_dram_refresh_ctrl (
    .clk(clk), .rst(rst), .mode_burst(mode_burst), .row_open(row_open),
    .sched_busy(sched_busy), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_row(cmd_row), .ref_busy(ref_busy), .sweep_done(sweep_done));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cmd_valid && log_n < 64) begin
      log_cyc[log_n]  <= cyc;
      log_kind[log_n] <= cmd_kind;
      log_row[log_n]  <= int'(cmd_row);
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_ep(input bit burst, input bit open, input bit hold,
                        input bit flip, input logic [1:0] first);
    int exp_acts, sweeps, viol, k, exp_sw;
    mode_burst = burst; row_open = open; sched_busy = hold;
    log_n = 0; sweeps = 0; viol = 0; exp_sw = 0;
    if (hold) begin
      for (int i = 0; i < HOLD; i++) begin
        @(negedge clk);
        if (ref_busy || cmd_valid) viol++;
      end
      chk(viol == 0, "R7 refresh started under sched_busy", viol, 0);
      sched_busy = 0;
    end
    while (!ref_busy) @(negedge clk);
    chk(cmd_valid == 1'b1, "R6 busy rises with first command", cmd_valid, 1);
    if (flip) begin mode_burst = !burst; row_open = !open; end
    while (ref_busy) begin
      @(negedge clk);
      if (sweep_done) sweeps++;
    end
    exp_acts = burst ? ROWS - model_row : 1;
    chk(log_n == 2 * exp_acts + int'(open),
        flip ? "R9 command count" : (burst ? "R4 command count" : "R1 command count"),
        log_n, 2 * exp_acts + int'(open));
    chk(log_kind[0] == first, "R3 first command kind", log_kind[0], first);
    last_start = log_cyc[0];
    if (log_n != 2 * exp_acts + int'(open)) return;
    k = 0;
    if (open) begin
      chk(log_cyc[1] - log_cyc[0] == T_RP, "R3 close to activate gap",
          log_cyc[1] - log_cyc[0], T_RP);
      k = 1;
    end
    for (int a = 0; a < exp_acts; a++) begin
      int ix = k + 2 * a;
      chk(log_kind[ix] == K_ACT && log_row[ix] == model_row, "R5 activate row",
          log_row[ix], model_row);
      chk(log_kind[ix+1] == K_PRE && log_cyc[ix+1] - log_cyc[ix] == T_RAS,
          "R2 activate to precharge", log_cyc[ix+1] - log_cyc[ix], T_RAS);
      if (a > 0)
        chk(log_cyc[ix] - log_cyc[ix-1] == T_RP, "R4 precharge to next activate",
            log_cyc[ix] - log_cyc[ix-1], T_RP);
      if (model_row == ROWS - 1) begin exp_sw = 1; model_row = 0; end
      else model_row++;
    end
    chk(sweeps == exp_sw, "R5 sweep_done pulses", sweeps, exp_sw);
  endtask

  initial begin
    int s1, s2, viol;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !ref_busy && !sweep_done && cmd_row == 0, "R8 outputs in reset",
        {cmd_valid, ref_busy, sweep_done}, 0);
    rst = 0;
    viol = 0;
    for (int i = 0; i < INTERVAL; i++) begin
      @(negedge clk);
      if (ref_busy || cmd_valid) viol++;
    end
    chk(viol == 0, "R1 no refresh before first interval", viol, 0);

    foreach (SCEN[i])
      run_ep(SCEN[i][4], SCEN[i][3], SCEN[i][2], 1'b1, SCEN[i][1:0]);

    // distributed spacing
    run_ep(0, 0, 0, 0, K_ACT);
    run_ep(0, 0, 0, 0, K_ACT); s1 = last_start;
    run_ep(0, 0, 0, 0, K_ACT); s2 = last_start;
    chk(s2 - s1 == INTERVAL, "R1 distributed spacing", s2 - s1, INTERVAL);

    // burst period
    run_ep(1, 0, 0, 0, K_ACT);
    run_ep(1, 0, 0, 0, K_ACT); s1 = last_start;
    run_ep(1, 0, 0, 0, K_ACT); s2 = last_start;
    chk(s2 - s1 == ROWS * INTERVAL, "R4 burst period", s2 - s1, ROWS * INTERVAL);

    // reset in the middle of a burst
    mode_burst = 1; row_open = 0;
    while (!ref_busy) @(negedge clk);
    repeat (9) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk(!ref_busy && !cmd_valid && !sweep_done, "R8 reset aborts burst",
        {ref_busy, cmd_valid, sweep_done}, 0);
    @(negedge clk);
    rst = 0;
    model_row = 0;
    @(negedge clk);
    chk(!ref_busy && !cmd_valid, "R8 idle after reset", {ref_busy, cmd_valid}, 0);
    run_ep(0, 0, 0, 0, K_ACT);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule